// File: doc/BRIEF.md
# Framed Command Receive Parser

This block sits behind a UART byte receiver and turns the incoming byte stream into command frames. A frame on the wire is a sync byte, a length byte, a type byte, `length` payload bytes and a closing CRC byte. The parser hunts for sync, checks the length against a configured maximum, stores the payload in a small local buffer and runs a CRC8 across the length, type and payload bytes as they arrive. The check is therefore ready in the same cycle the CRC byte shows up.

A frame that checks out is announced to the downstream command handler with a one-cycle strobe, together with its type and length. The handler then reads the payload bytes through a synchronous read port. A frame that fails is reported as a one-cycle NACK request toward the transmit side, carrying a command field and an error code. Whatever the outcome, the parser goes back to hunting for sync after the length abort or after the CRC byte.

Top module: `frame_rx_parser`

## Requirements
- R1: After synchronous reset `frm_valid` and `nack_valid` are low, and the parser is hunting for sync.
- R2: While hunting, any accepted byte other than the sync value (default 0xAA) is discarded and produces neither strobe.
- R3: A length byte greater than `MAX_PAYLOAD` raises `nack_valid` in the next cycle with `nack_cmd` = 0x00 and `nack_err` = 0x01 (bad length). The parser then hunts for sync, so the bytes that follow are not parsed as a frame.
- R4: A length of zero moves the parser straight from the type byte to the CRC byte. Such a frame is accepted when its CRC matches.
- R5: The CRC is CRC8 with polynomial 0x07 and initial value 0x00, shifted MSB first, over the length, type and payload bytes in arrival order. On a match, `frm_valid` is high for exactly the cycle after the CRC byte, with `frm_type` and `frm_len` set to the frame's type and length. A payload byte equal to the sync value is treated as data.
- R6: On a CRC mismatch, `nack_valid` is high for the cycle after the CRC byte, with `nack_cmd` equal to the received type and `nack_err` = 0x02 (bad CRC).
- R7: After the CRC byte the parser hunts for sync, whether the frame passed or failed. Frame bytes that follow without a new sync byte are ignored.
- R8: Payload byte i of the last good frame is returned on `pl_rdata` one cycle after `pl_raddr` = i. It remains available until the next frame's payload starts.
- R9: A cycle with `in_valid` low has no effect, whatever value `in_byte` holds.
- R10: `frm_valid` and `nack_valid` are never high in the same cycle, and neither is high for two consecutive cycles.
- R11: A frame whose length equals `MAX_PAYLOAD` is accepted, and all of its payload bytes can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a received byte this cycle |
| in_byte | input | 8 | Received byte |
| pl_raddr | input | $clog2(MAX_PAYLOAD) | Payload buffer read address |
| frm_valid | output | 1 | One-cycle strobe for a good frame |
| frm_type | output | 8 | Type byte of the last good frame |
| frm_len | output | $clog2(MAX_PAYLOAD+1) | Payload length of the last good frame |
| pl_rdata | output | 8 | Payload byte at `pl_raddr`, one cycle later |
| nack_valid | output | 1 | One-cycle NACK request |
| nack_cmd | output | 8 | Command field of the NACK (0x00 for a length abort) |
| nack_err | output | 8 | Error code: 0x01 bad length, 0x02 bad CRC |

## Verification
The bench builds the parser with `MAX_PAYLOAD` = 8 and keeps the default sync byte, polynomial and error codes. At that size, a full-length frame, the first oversize length (9) and every buffer address can all be reached within a few dozen cycles. A behavioural model that takes each byte and computes the CRC over the whole frame at its end predicts both strobes and their fields in every cycle. The model also holds the payload of the last good frame, so that reads through the payload port can be checked.

// File: rtl/frx_pkg.sv
package frx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_LEN,
    ST_TYPE,
    ST_BODY,
    ST_CHECK
  } frx_state_e;

  // One byte of CRC8, MSB first, no reflection.
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in,
                                           input logic [7:0] data,
                                           input logic [7:0] poly);
    logic [7:0] x;
    x = crc_in ^ data;
    for (int b = 0; b < 8; b++) begin
      x = x[7] ? ((x << 1) ^ poly) : (x << 1);
    end
    return x;
  endfunction

endpackage

// File: rtl/frx_crc8.sv
module frx_crc8 #(
  parameter logic [7:0] POLY = 8'h07,
  parameter logic [7:0] INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc_o
);
  import frx_pkg::*;

  logic [7:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q <= INIT;
    end else if (en) begin
      crc_q <= crc8_byte(crc_q, din, POLY);
    end
  end

  assign crc_o = crc_q;

  // Clearing and stepping belong to different parser states.
  assert_clr_en_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(clr && en));

endmodule

// File: rtl/frx_payload_ram.sv
module frx_payload_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  // Simple dual port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/frx_fsm.sv
module frx_fsm #(
  parameter logic [7:0] SYNC_BYTE   = 8'hAA,
  parameter int         MAX_PAYLOAD = 64,
  parameter logic [7:0] ERR_BAD_LEN = 8'h01,
  parameter logic [7:0] ERR_BAD_CRC = 8'h02,
  parameter int         LEN_W       = $clog2(MAX_PAYLOAD + 1),
  parameter int         AW          = $clog2(MAX_PAYLOAD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic [7:0]       crc_q,
  output logic             crc_clr,
  output logic             crc_en,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             frm_valid,
  output logic [7:0]       frm_type,
  output logic [LEN_W-1:0] frm_len,
  output logic             nack_valid,
  output logic [7:0]       nack_cmd,
  output logic [7:0]       nack_err
);
  import frx_pkg::*;

  localparam logic [7:0]       MAX_B = 8'(MAX_PAYLOAD);
  localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);

  frx_state_e       state_q, state_d;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx_q;
  logic [7:0]       type_q;
  logic             too_long;
  logic             last_body;
  logic             crc_ok;

  assign too_long  = in_byte > MAX_B;
  assign last_body = (idx_q + ONE) == len_q;
  assign crc_ok    = in_byte == crc_q;
  assign wr_addr   = idx_q[AW-1:0];

  always_comb begin
    state_d = state_q;
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    wr_en   = 1'b0;
    if (in_valid) begin
      unique case (state_q)
        ST_HUNT: begin
          if (in_byte == SYNC_BYTE) begin
            state_d = ST_LEN;
            crc_clr = 1'b1;
          end
        end
        ST_LEN: begin
          if (too_long) begin
            state_d = ST_HUNT;
          end else begin
            state_d = ST_TYPE;
            crc_en  = 1'b1;
          end
        end
        ST_TYPE: begin
          crc_en  = 1'b1;
          state_d = (len_q == '0) ? ST_CHECK : ST_BODY;
        end
        ST_BODY: begin
          crc_en = 1'b1;
          wr_en  = 1'b1;
          if (last_body) state_d = ST_CHECK;
        end
        ST_CHECK: state_d = ST_HUNT;
        default:  state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_HUNT;
      len_q      <= '0;
      idx_q      <= '0;
      type_q     <= '0;
      frm_valid  <= 1'b0;
      frm_type   <= '0;
      frm_len    <= '0;
      nack_valid <= 1'b0;
      nack_cmd   <= '0;
      nack_err   <= '0;
    end else begin
      state_q    <= state_d;
      frm_valid  <= 1'b0;
      nack_valid <= 1'b0;
      if (in_valid) begin
        unique case (state_q)
          ST_LEN: begin
            if (too_long) begin
              nack_valid <= 1'b1;
              nack_cmd   <= 8'h00;
              nack_err   <= ERR_BAD_LEN;
            end else begin
              len_q <= in_byte[LEN_W-1:0];
            end
          end
          ST_TYPE: begin
            type_q <= in_byte;
            idx_q  <= '0;
          end
          ST_BODY: idx_q <= idx_q + ONE;
          ST_CHECK: begin
            if (crc_ok) begin
              frm_valid <= 1'b1;
              frm_type  <= type_q;
              frm_len   <= len_q;
            end else begin
              nack_valid <= 1'b1;
              nack_cmd   <= type_q;
              nack_err   <= ERR_BAD_CRC;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_oversize_nack_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LEN && in_valid && in_byte > MAX_B) |=>
      (nack_valid && nack_cmd == 8'h00 && nack_err == ERR_BAD_LEN && state_q == ST_HUNT));

  assert_zero_len_skip_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TYPE && in_valid && len_q == '0) |=> (state_q == ST_CHECK));

  assert_crc_back_to_hunt_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK && in_valid) |=> (state_q == ST_HUNT));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(state_q));

  assert_body_bound_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BODY) |-> (idx_q < len_q));

endmodule

// File: rtl/frame_rx_parser.sv
module frame_rx_parser #(
  parameter logic [7:0] SYNC_BYTE   = 8'hAA,
  parameter int         MAX_PAYLOAD = 64,
  parameter logic [7:0] CRC_POLY    = 8'h07,
  parameter logic [7:0] ERR_BAD_LEN = 8'h01,
  parameter logic [7:0] ERR_BAD_CRC = 8'h02,
  parameter int         LEN_W       = $clog2(MAX_PAYLOAD + 1),
  parameter int         AW          = $clog2(MAX_PAYLOAD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic [AW-1:0]    pl_raddr,
  output logic             frm_valid,
  output logic [7:0]       frm_type,
  output logic [LEN_W-1:0] frm_len,
  output logic [7:0]       pl_rdata,
  output logic             nack_valid,
  output logic [7:0]       nack_cmd,
  output logic [7:0]       nack_err
);

  logic          crc_clr;
  logic          crc_en;
  logic [7:0]    crc_q;
  logic          wr_en;
  logic [AW-1:0] wr_addr;

  frx_fsm #(
    .SYNC_BYTE   (SYNC_BYTE),
    .MAX_PAYLOAD (MAX_PAYLOAD),
    .ERR_BAD_LEN (ERR_BAD_LEN),
    .ERR_BAD_CRC (ERR_BAD_CRC),
    .LEN_W       (LEN_W),
    .AW          (AW)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .crc_q      (crc_q),
    .crc_clr    (crc_clr),
    .crc_en     (crc_en),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .frm_valid  (frm_valid),
    .frm_type   (frm_type),
    .frm_len    (frm_len),
    .nack_valid (nack_valid),
    .nack_cmd   (nack_cmd),
    .nack_err   (nack_err)
  );

  frx_crc8 #(
    .POLY (CRC_POLY),
    .INIT (8'h00)
  ) u_crc (
    .clk   (clk),
    .rst   (rst),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (in_byte),
    .crc_o (crc_q)
  );

  frx_payload_ram #(
    .DEPTH (MAX_PAYLOAD),
    .AW    (AW)
  ) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (in_byte),
    .raddr (pl_raddr),
    .rdata (pl_rdata)
  );

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(frm_valid && nack_valid));

  assert_frm_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> !frm_valid);

  assert_nack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    nack_valid |=> !nack_valid);

  assert_len_in_range_R11: assert property (@(posedge clk) disable iff (rst)
    frm_valid |-> (int'(frm_len) <= MAX_PAYLOAD));

endmodule

// File: tb/frame_rx_parser_tb.sv
`timescale 1ns/100ps
module frame_rx_parser_tb;

  localparam int MAXP = 8;
  localparam int LW   = $clog2(MAXP + 1);
  localparam int AWB  = $clog2(MAXP);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [7:0]     in_byte = 8'h00;
  logic [AWB-1:0] pl_raddr = '0;
  logic           frm_valid;
  logic [7:0]     frm_type;
  logic [LW-1:0]  frm_len;
  logic [7:0]     pl_rdata;
  logic           nack_valid;
  logic [7:0]     nack_cmd;
  logic [7:0]     nack_err;

  always #2.5 clk = ~clk;

  frame_rx_parser #(.MAX_PAYLOAD(MAXP)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .pl_raddr(pl_raddr), .frm_valid(frm_valid), .frm_type(frm_type),
    .frm_len(frm_len), .pl_rdata(pl_rdata), .nack_valid(nack_valid),
    .nack_cmd(nack_cmd), .nack_err(nack_err)
  );

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Reference model state
  int   ms = 0;            // 0 hunt, 1 len, 2 type, 3 body, 4 crc
  int   m_len = 0;
  int   m_type = 0;
  int   frame_q[$];
  int   body_q[$];
  int   good_pl[$];
  bit   e_frm = 0, e_nack = 0;
  int   e_type = 0, e_len = 0, e_cmd = 0, e_err = 0;
  bit   rd_pend = 0;
  int   e_rd = 0;

  function automatic int ref_crc(input int q[$]);
    int c = 0;
    foreach (q[i]) begin
      c = c ^ q[i];
      for (int k = 0; k < 8; k++) c = (c & 8'h80) ? (((c << 1) ^ 8'h07) & 8'hFF) : ((c << 1) & 8'hFF);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(input int b);
    case (ms)
      0: if (b == 8'hAA) ms = 1;
      1: begin
        if (b > MAXP) begin
          e_nack = 1; e_cmd = 0; e_err = 1; ms = 0;
        end else begin
          m_len = b; frame_q = {b}; ms = 2;
        end
      end
      2: begin
        m_type = b; frame_q.push_back(b); body_q = {};
        ms = (m_len == 0) ? 4 : 3;
      end
      3: begin
        frame_q.push_back(b); body_q.push_back(b);
        if (body_q.size() == m_len) ms = 4;
      end
      default: begin
        if (b == ref_crc(frame_q)) begin
          e_frm = 1; e_type = m_type; e_len = m_len; good_pl = body_q;
        end else begin
          e_nack = 1; e_cmd = m_type; e_err = 2;
        end
        ms = 0;
      end
    endcase
  endtask

  // One clock: compare outputs for the previous cycle, then drive the next.
  task automatic step(input bit v, input int b, input int ra, input bit rd);
    @(negedge clk);
    check(!(frm_valid && nack_valid), "R10", "both strobes", {frm_valid, nack_valid}, 0);
    check(frm_valid == e_frm, cur_req, "frm_valid", frm_valid, e_frm);
    check(nack_valid == e_nack, cur_req, "nack_valid", nack_valid, e_nack);
    if (e_frm && frm_valid) begin
      check(frm_type == 8'(e_type), cur_req, "frm_type", frm_type, e_type);
      check(int'(frm_len) == e_len, cur_req, "frm_len", frm_len, e_len);
    end
    if (e_nack && nack_valid) begin
      check(nack_cmd == 8'(e_cmd), cur_req, "nack_cmd", nack_cmd, e_cmd);
      check(nack_err == 8'(e_err), cur_req, "nack_err", nack_err, e_err);
    end
    if (rd_pend) check(pl_rdata == 8'(e_rd), "R8", "pl_rdata", pl_rdata, e_rd);
    e_frm = 0; e_nack = 0;
    in_valid = v; in_byte = 8'(b); pl_raddr = AWB'(ra);
    rd_pend = rd;
    if (rd) e_rd = good_pl[ra];
    if (v) model(b);
  endtask

  task automatic put(input int b);
    step(1, b, 0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'hAA, 0, 0);
  endtask

  task automatic send_frame(input int typ, input int pl[$], input bit corrupt);
    int f[$];
    f = {pl.size(), typ};
    foreach (pl[i]) f.push_back(pl[i]);
    put(8'hAA);
    foreach (f[i]) put(f[i]);
    put(ref_crc(f) ^ (corrupt ? 8'h01 : 8'h00));
  endtask

  task automatic read_back();
    for (int i = 0; i < good_pl.size(); i++) step(0, 0, i, 1);
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(frm_valid == 0, "R1", "frm_valid after reset", frm_valid, 0);
    check(nack_valid == 0, "R1", "nack_valid after reset", nack_valid, 0);
    idle(2);

    // R2: bytes without a sync are discarded
    cur_req = "R2";
    put(8'h01); put(8'h00); put(8'h05); put(8'h33); put(8'h55);
    idle(2);

    // R5 and R8: good frame with a sync value inside the payload
    cur_req = "R5";
    send_frame(8'h10, '{8'h11, 8'hAA, 8'h22}, 0);
    idle(1);
    read_back();

    // R4: zero-length frame
    cur_req = "R4";
    send_frame(8'h21, '{}, 0);
    idle(2);

    // R6: CRC mismatch
    cur_req = "R6";
    send_frame(8'h33, '{8'h01, 8'h02}, 1);
    idle(1);

    // R7: frame body after the CRC byte without a new sync is ignored
    cur_req = "R7";
    send_frame(8'h44, '{8'h7E}, 0);
    put(8'h00); put(8'h05); put(ref_crc('{0, 5}));
    idle(2);

    // R3: oversize lengths abort and return to hunting
    cur_req = "R3";
    put(8'hAA); put(MAXP + 1); put(8'h00); put(8'h07); put(8'h07);
    idle(1);
    put(8'hAA); put(8'hFF); put(8'h12);
    idle(2);

    // R11: length at the limit, full read back
    cur_req = "R11";
    send_frame(8'h5C, '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7}, 0);
    idle(1);
    read_back();

    // R9: gaps with in_valid low, sync value on the idle bus
    cur_req = "R9";
    put(8'hAA); idle(2); put(2); step(0, 8'h99, 0, 0); put(8'h66);
    idle(1); put(8'hC3); idle(3); put(8'h3C);
    step(0, 8'h00, 0, 0);
    put(ref_crc('{2, 8'h66, 8'hC3, 8'h3C}));
    idle(2);
    read_back();

    // R10: back-to-back frames, good then bad then good
    cur_req = "R10";
    send_frame(8'h01, '{8'h10}, 0);
    send_frame(8'h02, '{8'h20, 8'h21}, 1);
    send_frame(8'h03, '{}, 0);
    idle(3);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule